// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries 36-bit words from a producer running on one clock to a consumer running on another clock. The two clocks may be unrelated or the same. The storage is a power-of-two deep memory. A Gray-coded pointer from each side crosses into the other clock domain through a short flop chain. Each side computes its own flags from its own pointer and the synchronized copy of the far pointer. Every flag therefore changes only on the edges of the clock of the side that reads it.

The write side has two flags:
- a room flag, high while a write can be accepted;
- an active-low almost-full flag, computed against a threshold of free locations.

The read side has two flags:
- an availability flag;
- an active-low almost-empty flag, computed against a threshold of stored words.

Both thresholds are captured from input pins while the owning side is held in reset.

A mode pin, latched on the first read-clock edge after reset, selects between two read timings:
- Standard: the availability flag means "memory not empty", and a word is put on the output at the edge that accepts the read.
- Fall-through: the head word is moved into the output register without any request. The availability flag then means "valid data on the output", and each accepted read moves on to the next word.

A port transfers a word only at an edge where its select is low and its enable is high.

Top module: `xfifo_dual_clock`

## Requirements
- R1: A write happens at a write-clock rising edge only if `wr_cs_n` is 0 and `wr_en` is 1. A read happens at a read-clock rising edge only if `rd_cs_n` is 0 and `rd_en` is 1. Any other combination moves no data.
- R2: Words leave in the order they were accepted, with their values unchanged, whatever the ratio between the two clocks.
- R3: `wr_room` is 0 while the memory holds DEPTH words. A write attempted while `wr_room` is 0 is dropped, and the stored contents are unchanged.
- R4: A read attempted while `rd_avail` is 0 is dropped. In standard mode `rd_data` keeps its value at every edge that accepts no read.
- R5: In standard mode `rd_avail` is 1 exactly when the memory holds at least one word. The word read appears on `rd_data` from the edge that accepts the read.
- R6: In fall-through mode the oldest word appears on `rd_data`, with `rd_avail` at 1, without any read request. Each accepted read presents the next word, or drops `rd_avail` to 0 if none is left.
- R7: Once the flags have settled, `rd_almost_empty_n` is 0 exactly when the readable word count is less than or equal to the almost-empty threshold. In fall-through mode the readable count includes the word held in the output register.
- R8: Once the flags have settled, `wr_almost_full_n` is 0 exactly when the free memory locations (DEPTH minus the words in memory) are less than or equal to the almost-full threshold.
- R9: The thresholds are taken from `ae_offset` and `af_offset` while the owning side is in reset. Later changes on those pins have no effect.
- R10: `mode_sel` is latched on the first read-clock edge after reset: 1 selects standard mode and 0 selects fall-through mode. Later changes on the pin have no effect.
- R11: After reset `rd_avail` is 0 and `wr_room` is 1. `rd_almost_empty_n` is 0, and `wr_almost_full_n` is 1 when the almost-full threshold is below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_cs_n | input | 1 | Write select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | DATA_W | Word to store |
| af_offset | input | AW+1 | Almost-full threshold, captured during reset |
| wr_room | output | 1 | High while a write can be accepted |
| wr_almost_full_n | output | 1 | Low when free locations are at or below the threshold |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| rd_cs_n | input | 1 | Read select, active low |
| rd_en | input | 1 | Read enable, active high |
| mode_sel | input | 1 | Timing mode: 1 standard, 0 fall-through |
| ae_offset | input | AW+1 | Almost-empty threshold, captured during reset |
| rd_data | output | DATA_W | Output word |
| rd_avail | output | 1 | Standard: memory not empty. Fall-through: output word valid |
| rd_almost_empty_n | output | 1 | Low when readable words are at or below the threshold |

## Verification
- A corrupted pointer or synchronizer shows up on `rd_data` at the next accepted read, as a word out of order or a repeated word. It shows up in the flags as a mismatch against the bench's word count, a few clock cycles after traffic stops.
- A lost prefetch in fall-through mode leaves `rd_avail` low while words are stored. This can be seen within the crossing latency of the first write.
- A wrong threshold capture makes an almost flag wrong at the first settled count that lies between the captured value and the pin's later value.
- A bad full condition either accepts a word too many, which appears as an extra word during the drain, or blocks short of DEPTH, which appears in the settled `wr_room` value.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    // Read timing mode, encoded as the level on the mode pin
    typedef enum logic {
        MODE_FWFT = 1'b0,
        MODE_STD  = 1'b1
    } xfifo_mode_e;

    typedef struct packed {
        logic room;
        logic almost_full_n;
    } wr_flags_t;

    typedef struct packed {
        logic avail;
        logic almost_empty_n;
    } rd_flags_t;

    // Widest pointer the conversion helpers accept
    localparam int unsigned PTR_MAX_W = 32;

    function automatic logic [PTR_MAX_W-1:0] to_gray(input logic [PTR_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_MAX_W-1:0] from_gray(input logic [PTR_MAX_W-1:0] g);
        logic [PTR_MAX_W-1:0] b;
        b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xfifo_ptr_sync.sv
module xfifo_ptr_sync #(
    parameter int unsigned W      = 12,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int unsigned DW = 36,
    parameter int unsigned AW = 11
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // The output register doubles as the fall-through holding register
    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/xfifo_wr_ctrl.sv
module xfifo_wr_ctrl
    import xfifo_pkg::*;
#(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          en,
    input  logic [AW:0]   af_off,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output wr_flags_t     flags
);

    localparam int unsigned PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic [PW-1:0] free;
    logic [PW-1:0] af_off_q;
    logic          full;

    assign rbin_s   = PW'(from_gray(PTR_MAX_W'(rgray_s)));
    assign used     = wbin - rbin_s;
    assign free     = DEPTH_P - used;
    assign full     = (used == DEPTH_P);
    assign we       = !cs_n && en && !full;
    assign wbin_nxt = wbin + PW'(1);
    assign waddr    = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin     <= '0;
            wgray    <= '0;
            af_off_q <= af_off;
        end else if (we) begin
            wbin  <= wbin_nxt;
            wgray <= PW'(to_gray(PTR_MAX_W'(wbin_nxt)));
        end
    end

    assign flags.room          = !full;
    assign flags.almost_full_n = !(free <= af_off_q);

    // R3: occupancy seen by the write side never exceeds the memory size
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH_P);

    // R2: the pointer sent across the clock boundary moves one Gray step at most
    assert_gray_step_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R8: a full memory has zero free locations, which is at or below any threshold
    assert_af_at_full_R8: assert property (@(posedge clk) disable iff (rst)
        !flags.room |-> !flags.almost_full_n);

endmodule

// File: rtl/xfifo_rd_ctrl.sv
module xfifo_rd_ctrl
    import xfifo_pkg::*;
#(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          en,
    input  logic          mode_in,
    input  logic [AW:0]   ae_off,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] rdata,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output rd_flags_t     flags
);

    localparam int unsigned PW = AW + 1;
    localparam logic [PW-1:0] CAP_P = PW'((1 << AW) + 1);

    xfifo_mode_e   mode_q;
    logic          mode_lock;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] count;
    logic [PW-1:0] ae_off_q;
    logic          ov;
    logic          std;
    logic          req;
    logic          mem_empty;

    assign std       = (mode_q == MODE_STD);
    assign req       = !cs_n && en;
    assign wbin_s    = PW'(from_gray(PTR_MAX_W'(wgray_s)));
    assign mem_empty = (wbin_s == rbin);
    assign rbin_nxt  = rbin + PW'(1);
    assign raddr     = rbin[AW-1:0];

    // Standard: fetch on request. Fall-through: refill whenever the output slot frees.
    always_comb begin
        if (std) begin
            re = req && !mem_empty;
        end else begin
            re = !mem_empty && (!ov || req);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= xfifo_mode_e'(mode_in);
            mode_lock <= 1'b0;
            ae_off_q  <= ae_off;
            rbin      <= '0;
            rgray     <= '0;
            ov        <= 1'b0;
        end else begin
            if (!mode_lock) begin
                mode_q    <= xfifo_mode_e'(mode_in);
                mode_lock <= 1'b1;
            end
            if (re) begin
                rbin  <= rbin_nxt;
                rgray <= PW'(to_gray(PTR_MAX_W'(rbin_nxt)));
            end
            if (!std) begin
                if (re) begin
                    ov <= 1'b1;
                end else if (req && ov) begin
                    ov <= 1'b0;
                end
            end
        end
    end

    assign count = (wbin_s - rbin) + {{AW{1'b0}}, (ov && !std)};

    assign flags.avail          = std ? !mem_empty : ov;
    assign flags.almost_empty_n = !(count <= ae_off_q);

    // R6: an unread fall-through word stays valid and unchanged
    assert_fwft_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!std && ov && !req) |=> (ov && $stable(rdata)));

    // R4: with nothing stored, the standard-mode output does not move
    assert_std_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (std && mem_empty) |=> $stable(rdata));

    // R10: the latched mode never changes once taken
    assert_mode_fixed_R10: assert property (@(posedge clk) disable iff (rst)
        mode_lock |=> $stable(mode_q));

    // R7: readable words never exceed memory plus output register
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CAP_P);

endmodule

// File: rtl/xfifo_dual_clock.sv
module xfifo_dual_clock
    import xfifo_pkg::*;
#(
    parameter int unsigned DATA_W      = 36,
    parameter int unsigned DEPTH       = 2048,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW         = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_cs_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW:0]       af_offset,
    output logic              wr_room,
    output logic              wr_almost_full_n,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_cs_n,
    input  logic              rd_en,
    input  logic              mode_sel,
    input  logic [AW:0]       ae_offset,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_avail,
    output logic              rd_almost_empty_n
);

    logic          we;
    logic          re;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [AW:0]   wgray;
    logic [AW:0]   rgray;
    logic [AW:0]   wgray_rd;
    logic [AW:0]   rgray_wr;
    wr_flags_t     wflags;
    rd_flags_t     rflags;

    xfifo_wr_ctrl #(.AW(AW)) u_wr (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .cs_n    (wr_cs_n),
        .en      (wr_en),
        .af_off  (af_offset),
        .rgray_s (rgray_wr),
        .we      (we),
        .waddr   (waddr),
        .wgray   (wgray),
        .flags   (wflags)
    );

    xfifo_ptr_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wgray),
        .q   (wgray_rd)
    );

    xfifo_ptr_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rgray),
        .q   (rgray_wr)
    );

    xfifo_ram #(.DW(DATA_W), .AW(AW)) u_ram (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .re    (re),
        .raddr (raddr),
        .rdata (rd_data)
    );

    xfifo_rd_ctrl #(.AW(AW), .DW(DATA_W)) u_rd (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .cs_n    (rd_cs_n),
        .en      (rd_en),
        .mode_in (mode_sel),
        .ae_off  (ae_offset),
        .wgray_s (wgray_rd),
        .rdata   (rd_data),
        .re      (re),
        .raddr   (raddr),
        .rgray   (rgray),
        .flags   (rflags)
    );

    assign wr_room           = wflags.room;
    assign wr_almost_full_n  = wflags.almost_full_n;
    assign rd_avail          = rflags.avail;
    assign rd_almost_empty_n = rflags.almost_empty_n;

endmodule

// File: tb/xfifo_dual_clock_tb.sv
module xfifo_dual_clock_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int DEPTH_B    = 32;
    localparam int AW_B       = $clog2(DEPTH_B);

    logic            wr_clk = 0, rd_clk = 0;
    logic            wr_rst = 1, rd_rst = 1;
    logic            wr_cs_n = 1, wr_en = 0, rd_cs_n = 1, rd_en = 0;
    logic            mode_sel = 1;
    logic [35:0]     wr_data = '0;
    logic [AW_B:0]   af_offset = '0, ae_offset = '0;
    logic            wr_room, wr_almost_full_n, rd_avail, rd_almost_empty_n;
    logic [35:0]     rd_data;

    int          checks = 0, errors = 0;
    bit          done = 0;
    bit          std_m = 1;
    int          cur_x, cur_y;
    logic [35:0] q[$];
    bit          pend = 0, have_last = 0;
    logic [35:0] pend_val, last_out;

    xfifo_dual_clock #(.DATA_W(36), .DEPTH(DEPTH_B)) u_dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_cs_n(wr_cs_n), .wr_en(wr_en),
        .wr_data(wr_data), .af_offset(af_offset), .wr_room(wr_room),
        .wr_almost_full_n(wr_almost_full_n), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .mode_sel(mode_sel), .ae_offset(ae_offset),
        .rd_data(rd_data), .rd_avail(rd_avail), .rd_almost_empty_n(rd_almost_empty_n)
    );

    initial forever #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    initial forever #(RD_PERIOD / 2) rd_clk = ~rd_clk;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic bit exp_ae_n(input int cnt);
        return !(cnt <= cur_x);
    endfunction

    function automatic bit exp_af_n(input int mem);
        return !((DEPTH_B - mem) <= cur_y);
    endfunction

    task automatic do_reset(input bit std_mode, input int x, input int y);
        @(negedge wr_clk);
        wr_rst = 1; rd_rst = 1;
        wr_en = 0; rd_en = 0; wr_cs_n = 1; rd_cs_n = 1;
        mode_sel = std_mode;
        ae_offset = (AW_B + 1)'(x);
        af_offset = (AW_B + 1)'(y);
        std_m = std_mode; cur_x = x; cur_y = y;
        q.delete(); pend = 0; have_last = 0;
        repeat (6) @(posedge rd_clk);
        @(negedge wr_clk); wr_rst = 0;
        @(negedge rd_clk); rd_rst = 0;
        repeat (3) @(negedge rd_clk);
    endtask

    // Random traffic on both clocks; writer and reader obey the flags
    task automatic run_traffic(input int ncyc, input int wp, input int rp, input int desel);
        fork
            begin
                for (int i = 0; i <= ncyc; i++) begin
                    logic [35:0] d;
                    bit cs, en;
                    @(negedge wr_clk);
                    d  = {4'($urandom()), $urandom()};
                    cs = (int'($urandom() % 100) < desel);
                    en = (i < ncyc) && (int'($urandom() % 100) < wp);
                    wr_cs_n = cs; wr_en = en; wr_data = d;
                    if (!cs && en && wr_room) q.push_back(d);
                end
                @(negedge wr_clk);
                wr_en = 0; wr_cs_n = 1;
            end
            begin
                for (int i = 0; i <= ncyc; i++) begin
                    bit cs, en;
                    @(negedge rd_clk);
                    if (std_m) begin
                        if (pend) begin
                            chk(rd_data == pend_val, "R2 R5 standard read data", 64'(rd_data), 64'(pend_val));
                            have_last = 1;
                        end else if (have_last) begin
                            chk(rd_data == last_out, "R4 output held without accepted read", 64'(rd_data), 64'(last_out));
                        end
                        last_out = rd_data;
                        pend = 0;
                    end else if (rd_avail) begin
                        if (q.size() == 0) chk(0, "R6 valid flag with nothing written", 1, 0);
                        else chk(rd_data == q[0], "R2 R6 fall-through head word", 64'(rd_data), 64'(q[0]));
                    end
                    cs = (int'($urandom() % 100) < desel);
                    en = (i < ncyc) && (int'($urandom() % 100) < rp);
                    rd_cs_n = cs; rd_en = en;
                    if (!cs && en && rd_avail) begin
                        if (q.size() == 0) begin
                            chk(0, "R4 read accepted from empty FIFO", 1, 0);
                        end else if (std_m) begin
                            pend_val = q.pop_front();
                            pend = 1;
                        end else begin
                            void'(q.pop_front());
                        end
                    end
                end
                @(negedge rd_clk);
                rd_en = 0; rd_cs_n = 1;
            end
        join
    endtask

    task automatic settle_check();
        int cnt, mem;
        repeat (8) @(negedge rd_clk);
        cnt = q.size();
        mem = std_m ? cnt : ((cnt > 0) ? cnt - 1 : 0);
        if (std_m) chk(rd_avail == (cnt > 0), "R5 not-empty flag", 64'(rd_avail), 64'(cnt > 0));
        else       chk(rd_avail == (cnt > 0), "R6 output-valid flag", 64'(rd_avail), 64'(cnt > 0));
        chk(rd_almost_empty_n == exp_ae_n(cnt), "R7 almost-empty flag", 64'(rd_almost_empty_n), 64'(exp_ae_n(cnt)));
        @(negedge wr_clk);
        chk(wr_room == (mem < DEPTH_B), "R3 room flag", 64'(wr_room), 64'(mem < DEPTH_B));
        chk(wr_almost_full_n == exp_af_n(mem), "R8 almost-full flag", 64'(wr_almost_full_n), 64'(exp_af_n(mem)));
    endtask

    task automatic reset_state_check();
        @(negedge wr_clk);
        chk(wr_room == 1'b1, "R11 room after reset", 64'(wr_room), 1);
        chk(wr_almost_full_n == exp_af_n(0), "R11 almost-full after reset", 64'(wr_almost_full_n), 64'(exp_af_n(0)));
        @(negedge rd_clk);
        chk(rd_avail == 1'b0, "R11 avail after reset", 64'(rd_avail), 0);
        chk(rd_almost_empty_n == 1'b0, "R11 almost-empty after reset", 64'(rd_almost_empty_n), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // Phase 1: standard mode, thresholds 8/8
        do_reset(1'b1, 8, 8);
        reset_state_check();
        mode_sel = 1'b0;                         // R10: ignored after latch
        run_traffic(3000, 60, 50, 12);
        settle_check();
        run_traffic(DEPTH_B + 10, 100, 0, 0);    // fill, then pound on a full FIFO (R3)
        settle_check();
        chk(wr_room == 1'b0, "R3 full blocks writes", 64'(wr_room), 0);
        run_traffic(10, 100, 0, 0);
        settle_check();
        run_traffic(3 * DEPTH_B, 0, 100, 0);     // drain, then read while empty (R4)
        settle_check();
        run_traffic(5, 100, 0, 0);
        settle_check();
        run_traffic(40, 100, 100, 100);          // R1: deselected ports move nothing
        settle_check();
        chk(rd_avail == 1'b1, "R1 deselected traffic left data in place", 64'(rd_avail), 1);
        run_traffic(30, 0, 100, 0);
        settle_check();
        chk(rd_avail == 1'b0, "R1 no extra word stored while deselected", 64'(rd_avail), 0);
        run_traffic(1500, 80, 90, 5);
        settle_check();

        // Phase 2: fall-through mode, thresholds 3/5, pins moved after reset (R9)
        do_reset(1'b0, 3, 5);
        reset_state_check();
        ae_offset = (AW_B + 1)'(20);
        af_offset = (AW_B + 1)'(20);
        mode_sel = 1'b1;                         // R10
        run_traffic(1, 100, 0, 0);
        repeat (10) @(negedge rd_clk);
        chk(rd_avail == 1'b1, "R6 first word falls through", 64'(rd_avail), 1);
        if (q.size() > 0)
            chk(rd_data == q[0], "R6 first word value", 64'(rd_data), 64'(q[0]));
        run_traffic(3, 100, 0, 0);
        settle_check();
        chk(rd_almost_empty_n == 1'b1, "R9 almost-empty uses captured threshold", 64'(rd_almost_empty_n), 1);
        chk(wr_almost_full_n == 1'b1, "R9 almost-full uses captured threshold", 64'(wr_almost_full_n), 1);
        run_traffic(2000, 70, 40, 10);
        settle_check();
        run_traffic(2000, 40, 80, 10);
        settle_check();
        run_traffic(DEPTH_B + 10, 100, 0, 0);
        settle_check();
        run_traffic(3 * DEPTH_B, 0, 100, 0);
        settle_check();

        // Phase 3: standard mode, zero thresholds (flags only at the extremes)
        do_reset(1'b1, 0, 0);
        reset_state_check();
        run_traffic(1, 100, 0, 0);
        settle_check();
        run_traffic(DEPTH_B + 4, 100, 0, 0);
        settle_check();
        run_traffic(1500, 50, 50, 20);
        settle_check();
        run_traffic(3 * DEPTH_B, 0, 100, 0);
        settle_check();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule